// File: doc/BRIEF.md
# Latched BCD Seven-Segment Decoder with Display-Frequency Polarity

This block turns a 4-bit code into the seven segment drives of one display digit. Every one of the sixteen codes has a glyph. Codes 0 to 9 show the decimal digits. The six codes above 9 show the letters L, H, P and A, a dash, and an empty digit. A strobe-controlled latch sits in front of the decoder. While the strobe is high the latch is transparent. While the strobe is low the latch keeps the last code it took in.

A display-frequency input sets the output polarity. Held low, it drives lit segments high, which suits common-cathode LEDs. Held high, it drives lit segments low. Fed a square wave, it makes lit segments run in antiphase with it and dark segments run in phase with it. That is the AC drive a liquid-crystal panel needs. A buffered copy of the display-frequency input is brought out to drive the panel's common electrode.

The latch is built synchronously. A clock-enabled register takes in the code on each rising clock edge while the strobe is high. A bypass path makes the live code visible at once while the strobe is high. When the strobe is low, the register's contents are shown. The segment outputs follow the display-frequency input combinationally, with no clock delay.

Top module: `lcd_digit_driver`

## Requirements
- R1: Segment bus bit 0 is segment a, bit 1 is b, and so on up to bit 6, which is g. With df_in low, codes 0 to 15 light these segments (hex, bit 6 down to bit 0): 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F, 38, 76, 73, 77, 40, 00.
- R2: With df_in low, every lit segment is driven 1 and every dark segment is driven 0.
- R3: With df_in high, every lit segment is driven 0 and every dark segment is driven 1. The output is the bitwise complement of the R1 pattern.
- R4: When df_in toggles while the shown code is unchanged, every segment output toggles in the same cycle. Lit segments stay opposite to df_in and dark segments stay equal to it.
- R5: While strobe is high, the shown code is code_in of the same cycle. A change of code_in reaches seg_out with no clock edge.
- R6: While strobe is low, seg_out keeps showing the code that was present at the last rising clock edge with strobe high. Changes on code_in have no effect.
- R7: df_out always equals df_in.
- R8: After reset, with strobe low, the held code is 15, so the digit is blank (seg_out = 00 with df_in low).
- R9: Glyph details: digit 6 lights segment a, digit 9 lights segment d, digit 7 lights only a, b and c, and the letter H (code 11) lights b, c, e, f and g.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the code-holding register |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe | input | 1 | High: latch transparent; low: hold |
| code_in | input | 4 | Code to display |
| df_in | input | 1 | Display-frequency / polarity select |
| seg_out | output | 7 | Segment drives, bit 0 = a ... bit 6 = g |
| df_out | output | 1 | Buffered display frequency for the common electrode |

## Verification
All sixteen codes are applied with df_in held low and again with df_in held high. The low pass tells a correct glyph table apart from a swapped or missing segment. The high pass tells true inversion apart from a stuck polarity. df_in is then toggled as a square wave over fixed codes, which shows whether each output follows the display frequency without a clock. The strobe is dropped and code_in is changed underneath it, which shows whether the design holds the captured code or leaks the live one.

// File: rtl/lcd_digit_pkg.sv
package lcd_digit_pkg;
  localparam int CODE_W = 4;
  localparam int SEG_W  = 7;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [SEG_W-1:0]  seg_t;

  // Glyph lookup, bit 0 = segment a ... bit 6 = segment g
  function automatic seg_t glyph(input code_t c);
    seg_t s;
    unique case (c)
      4'd0:  s = 7'h3F;
      4'd1:  s = 7'h06;
      4'd2:  s = 7'h5B;
      4'd3:  s = 7'h4F;
      4'd4:  s = 7'h66;
      4'd5:  s = 7'h6D;
      4'd6:  s = 7'h7D;
      4'd7:  s = 7'h07;
      4'd8:  s = 7'h7F;
      4'd9:  s = 7'h6F;
      4'd10: s = 7'h38;  // L
      4'd11: s = 7'h76;  // H
      4'd12: s = 7'h73;  // P
      4'd13: s = 7'h77;  // A
      4'd14: s = 7'h40;  // dash
      default: s = 7'h00; // blank
    endcase
    return s;
  endfunction
endpackage

// File: rtl/code_latch.sv
module code_latch #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_CODE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe_i,
  input  logic [W-1:0] code_i,
  output logic [W-1:0] code_o
);
  logic [W-1:0] held_q;
  logic [W-1:0] held_d;
  logic         held_en;

  assign held_en = strobe_i;

  always_comb begin
    held_d = held_q;
    if (held_en) held_d = code_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= RST_CODE;
    else        held_q <= held_d;
  end

  assign code_o = strobe_i ? code_i : held_q;

  // R6: with strobe low on consecutive cycles the shown code cannot move
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_i && !$past(strobe_i)) |-> (code_o == $past(code_o)));

  // R6: on the falling strobe the last transparent code is kept
  a_r6_capture_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(strobe_i) && !strobe_i) |-> (code_o == $past(code_i)));
endmodule

// File: rtl/glyph_decoder.sv
module glyph_decoder
  import lcd_digit_pkg::*;
(
  input  code_t code_i,
  output seg_t  sel_o
);
  always_comb sel_o = glyph(code_i);
endmodule

// File: rtl/polarity_stage.sv
module polarity_stage #(
  parameter int N = 7
) (
  input  logic [N-1:0] sel_i,
  input  logic         df_i,
  output logic [N-1:0] drv_o
);
  for (genvar i = 0; i < N; i++) begin : g_seg
    assign drv_o[i] = sel_i[i] ^ df_i;
  end
endmodule

// File: rtl/lcd_digit_driver.sv
module lcd_digit_driver
  import lcd_digit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [CODE_W-1:0] code_in,
  input  logic              df_in,
  output logic [SEG_W-1:0]  seg_out,
  output logic              df_out
);
  code_t shown_code;
  seg_t  sel;

  code_latch #(.W(CODE_W), .RST_CODE({CODE_W{1'b1}})) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (strobe),
    .code_i   (code_in),
    .code_o   (shown_code)
  );

  glyph_decoder u_dec (
    .code_i (shown_code),
    .sel_o  (sel)
  );

  polarity_stage #(.N(SEG_W)) u_pol (
    .sel_i (sel),
    .df_i  (df_in),
    .drv_o (seg_out)
  );

  assign df_out = df_in;

  // R4: a toggle of df_in over an unchanged code flips every segment
  a_r4_df_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
    ((df_in != $past(df_in)) && (shown_code == $past(shown_code)))
      |-> (seg_out == ~$past(seg_out)));

  // R7: common-electrode drive tracks the display frequency
  a_r7_df_follow: assert property (@(posedge clk) disable iff (!rst_n)
    df_out == df_in);

  // R8: a blank digit never drives a segment opposite to df
  a_r8_blank_is_df: assert property (@(posedge clk) disable iff (!rst_n)
    (shown_code == 4'hF) |-> (seg_out == {SEG_W{df_in}}));

  // R9: digit 8 with df low lights every segment
  a_r9_eight_full: assert property (@(posedge clk) disable iff (!rst_n)
    (shown_code == 4'd8 && !df_in) |-> (&seg_out));
endmodule

// File: tb/sim_lcd_digit_driver.sv
module sim_lcd_digit_driver;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       strobe;
  logic [3:0] code_in;
  logic       df_in;
  logic [6:0] seg_out;
  logic       df_out;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  lcd_digit_driver u0 (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .code_in(code_in),
    .df_in(df_in), .seg_out(seg_out), .df_out(df_out)
  );

  function automatic logic [6:0] exp_glyph(input logic [3:0] c);
    logic [6:0] t [16];
    t = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
          7'h7F, 7'h6F, 7'h38, 7'h76, 7'h73, 7'h77, 7'h40, 7'h00};
    return t[c];
  endfunction

  task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Move to just after a falling edge, away from the active edge
  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; strobe = 1'b0; code_in = 4'd3; df_in = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R8 reset blank", seg_out, 7'h00);
    code_in = 4'd8; step();
    chk("R8 reset hold ignores code", seg_out, 7'h00);
  endtask

  task automatic t_table(input logic df);
    df_in = df; strobe = 1'b1;
    for (int i = 0; i < 16; i++) begin
      code_in = 4'(i);
      #1;
      chk(df ? "R3 df high inverted" : "R1 R2 df low table", seg_out,
          df ? ~exp_glyph(4'(i)) : exp_glyph(4'(i)));
      step();
    end
  endtask

  task automatic t_glyph_details();
    df_in = 1'b0; strobe = 1'b1;
    code_in = 4'd6; #1; chk("R9 six has a", {6'd0, seg_out[0]}, 7'd1);
    code_in = 4'd9; #1; chk("R9 nine has d", {6'd0, seg_out[3]}, 7'd1);
    code_in = 4'd7; #1; chk("R9 seven abc only", seg_out, 7'b0000111);
    code_in = 4'd11; #1; chk("R9 H segments", seg_out, 7'b1110110);
    step();
  endtask

  task automatic t_square(input logic [3:0] c);
    strobe = 1'b1; code_in = c; df_in = 1'b0; step();
    for (int k = 0; k < 6; k++) begin
      df_in = ~df_in; #1;
      chk("R4 df square wave", seg_out, exp_glyph(c) ^ {7{df_in}});
      chk("R7 df_out copy", {6'd0, df_out}, {6'd0, df_in});
      step();
    end
  endtask

  task automatic t_hold();
    df_in = 1'b0; strobe = 1'b1; code_in = 4'd2; step();
    code_in = 4'd5; #1;
    chk("R5 transparent no clock", seg_out, exp_glyph(4'd5));
    step();
    strobe = 1'b0; #1;
    chk("R6 hold after fall", seg_out, exp_glyph(4'd5));
    for (int k = 0; k < 4; k++) begin
      code_in = 4'(k + 10); step();
      chk("R6 code ignored while low", seg_out, exp_glyph(4'd5));
    end
    df_in = 1'b1; #1;
    chk("R6 R3 held code inverted", seg_out, ~exp_glyph(4'd5));
    df_in = 1'b0;
    strobe = 1'b1; #1;
    chk("R5 reopen shows live", seg_out, exp_glyph(4'd13));
    step();
  endtask

  initial begin
    t_reset();
    t_table(1'b0);
    t_table(1'b1);
    t_glyph_details();
    t_square(4'd4);
    t_square(4'd15);
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule